// File: doc/BRIEF.md
# Nibble-Coded Register Access Port

This block turns a host byte stream into accesses on an 8-bit register file. Every incoming byte carries a 4-bit command code in its upper half and a 4-bit payload in its lower half. Two address commands set the register address one nibble at a time. Two data commands build one byte, and the second of the two commits the write. A read command returns the addressed register as one byte on a response stream.

Both write commits and reads can step the address forward. A host can therefore set one address and then stream a burst of writes, or a burst of reads. A typical burst is six reads that return two 24-bit positions, least significant byte first. The register file sits outside the block. It is reached through a write strobe, an address, write data and a combinational read-data input.

Top module: `nibble_reg_port`

## Requirements
- R1: After reset the response output is invalid, no write is strobed, the input is ready, and the register address is 0x00.
- R2: An accepted byte with code 0x0 loads its payload into address bits 3:0. Code 0x1 loads its payload into address bits 7:4. The other address bits are kept.
- R3: Code 0x2 stores its payload as the pending low data nibble. Code 0x3 asserts the write strobe in the cycle the byte is accepted. In that cycle the write data is {payload, pending low nibble} and the target is the current address.
- R4: Each committed write advances the address by one, so successive low/high data pairs fill consecutive registers.
- R5: Code 0x4 (read) captures the register at the current address. The captured byte appears on the response output, with its valid flag set, in the cycle after acceptance.
- R6: In a read byte, payload bit 0 set advances the address by one after the read. Bit 0 clear leaves the address unchanged.
- R7: Address advance wraps from 0xFF to 0x00.
- R8: Bytes with codes 0x5 to 0xF are accepted and dropped. They change neither the address nor any register, and produce no response.
- R9: While a response is valid and the response ready input is low, the input ready is low and the response data and valid flag hold their values.
- R10: Six consecutive reads with the advance flag return six consecutive registers in address order. A host assembles them as two 24-bit little-endian values, the first returned value first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | 8 | Command byte: code in 7:4, payload in 3:0 |
| inValid | input | 1 | Command byte present |
| inReady | output | 1 | Block takes the byte this cycle |
| rspData | output | 8 | Read result byte |
| rspValid | output | 1 | Read result present |
| rspReady | input | 1 | Consumer takes the result |
| regWrEn | output | 1 | Register write strobe |
| regAddr | output | 8 | Register address for read and write |
| regWrData | output | 8 | Register write data |
| regRdData | input | 8 | Register content at regAddr, combinational |

## Verification
The assertions assume that regRdData reflects regAddr in the same cycle, with no added latency. They also assume that inValid and inData are held steady until inReady accepts the byte. The stimulus models the register file as a bench array read combinationally. It drives every byte at the falling edge and keeps it applied until a ready cycle has passed. The response consumer lowers rspReady only between bytes, never partway through a handshake.

// File: rtl/nibble_reg_pkg.sv
package nibble_reg_pkg;
  localparam int NIB_W  = 4;
  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    CMD_ADDR_LO  = 4'h0,
    CMD_ADDR_HI  = 4'h1,
    CMD_DATA_LO  = 4'h2,
    CMD_DATA_WR  = 4'h3,
    CMD_READ     = 4'h4
  } cmdE;

  // Strobes from the control decoder to the datapath.
  typedef struct packed {
    logic setAddrLo;
    logic setAddrHi;
    logic setDataLo;
    logic commitWrite;
    logic loadResp;
    logic advance;
    logic dropResp;
  } strobeT;
endpackage

// File: rtl/nibble_reg_ctrl.sv
module nibble_reg_ctrl
  import nibble_reg_pkg::*;
#(
  parameter int NIBW  = NIB_W,
  parameter int CODEW = CODE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [CODEW-1:0] inCode,
  input  logic [NIBW-1:0]  inPayload,
  input  logic             rspValid,
  input  logic             rspReady,
  output logic             inReady,
  output strobeT           strb
);
  logic accept;

  // A pending response that cannot drain blocks every command byte.
  assign inReady = !rspValid || rspReady;
  assign accept  = inValid && inReady;

  always_comb begin
    strb = '0;
    strb.dropResp = rspValid && rspReady;
    if (accept) begin
      case (inCode)
        CMD_ADDR_LO: strb.setAddrLo   = 1'b1;
        CMD_ADDR_HI: strb.setAddrHi   = 1'b1;
        CMD_DATA_LO: strb.setDataLo   = 1'b1;
        CMD_DATA_WR: strb.commitWrite = 1'b1;
        CMD_READ:    strb.loadResp    = 1'b1;
        default:     ;
      endcase
    end
    strb.advance = strb.commitWrite || (strb.loadResp && inPayload[0]);
  end

  // R3: at most one action strobe per accepted byte
  a_r3_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.setAddrLo, strb.setAddrHi, strb.setDataLo,
                strb.commitWrite, strb.loadResp}) <= 1);

  // R9: no read is taken while the held response is stalled
  a_r9_no_load_when_stalled: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |-> !strb.loadResp);
endmodule

// File: rtl/nibble_reg_dp.sv
module nibble_reg_dp
  import nibble_reg_pkg::*;
#(
  parameter int NIBW = NIB_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [NIBW-1:0]   inPayload,
  input  logic [2*NIBW-1:0] regRdData,
  output logic [2*NIBW-1:0] addr,
  output logic [2*NIBW-1:0] wrData,
  output logic [2*NIBW-1:0] rspData,
  output logic              rspValid
);
  localparam int WORD_W = 2 * NIBW;

  logic [NIBW-1:0] dataLo;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr <= '0;
    end else if (strb.setAddrLo) begin
      addr[NIBW-1:0] <= inPayload;
    end else if (strb.setAddrHi) begin
      addr[WORD_W-1:NIBW] <= inPayload;
    end else if (strb.advance) begin
      addr <= addr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               dataLo <= '0;
    else if (strb.setDataLo) dataLo <= inPayload;
  end

  assign wrData = {inPayload, dataLo};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else if (strb.loadResp) begin
      rspValid <= 1'b1;
      rspData  <= regRdData;
    end else if (strb.dropResp) begin
      rspValid <= 1'b0;
    end
  end

  // R4 R6 R7: an advance moves the address by exactly one, modulo 256
  a_r4_advance_by_one: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> addr == $past(addr) + 1'b1);

  // R6: a read without the flag keeps the address
  a_r6_read_keeps_addr: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadResp && !strb.advance) |=> $stable(addr));

  // R9: a held response does not change while stalled
  a_r9_resp_stable: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !strb.dropResp && !strb.loadResp) |=> rspValid && $stable(rspData));
endmodule

// File: rtl/nibble_reg_port.sv
module nibble_reg_port
  import nibble_reg_pkg::*;
#(
  parameter int NIBW  = NIB_W,
  parameter int CODEW = CODE_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [CODEW+NIBW-1:0] inData,
  input  logic                  inValid,
  output logic                  inReady,
  output logic [2*NIBW-1:0]     rspData,
  output logic                  rspValid,
  input  logic                  rspReady,
  output logic                  regWrEn,
  output logic [2*NIBW-1:0]     regAddr,
  output logic [2*NIBW-1:0]     regWrData,
  input  logic [2*NIBW-1:0]     regRdData
);
  localparam int BYTE_W = CODEW + NIBW;

  strobeT           strb;
  logic [CODEW-1:0] inCode;
  logic [NIBW-1:0]  inPayload;

  assign inCode    = inData[BYTE_W-1:NIBW];
  assign inPayload = inData[NIBW-1:0];

  nibble_reg_ctrl #(.NIBW(NIBW), .CODEW(CODEW)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inCode(inCode),
    .inPayload(inPayload), .rspValid(rspValid), .rspReady(rspReady),
    .inReady(inReady), .strb(strb)
  );

  nibble_reg_dp #(.NIBW(NIBW)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .inPayload(inPayload),
    .regRdData(regRdData), .addr(regAddr), .wrData(regWrData),
    .rspData(rspData), .rspValid(rspValid)
  );

  assign regWrEn = strb.commitWrite;

  // R1 R3: a write only ever comes from an accepted byte
  a_r3_write_on_accept: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (inValid && inReady));

  // R5: an accepted read presents a response next cycle
  a_r5_read_responds: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inCode == CMD_READ) |=> rspValid);

  // R8: unknown codes leave the address alone and write nothing
  a_r8_unknown_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inCode > CMD_READ) |-> !regWrEn ##1 $stable(regAddr));
endmodule

// File: tb/sim_nibble_reg_port.sv
module sim_nibble_reg_port;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] inData = '0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic [7:0] rspData;
  logic       rspValid;
  logic       rspReady = 1'b1;
  logic       regWrEn;
  logic [7:0] regAddr;
  logic [7:0] regWrData;
  logic [7:0] regRdData;

  int checks = 0;
  int errors = 0;

  logic [7:0]  rf     [256];
  logic [7:0]  expMem [256];
  logic [7:0]  mAddr;
  logic [7:0]  expRsp[$];
  string       rspTag[$];
  logic [15:0] expWr[$];
  logic [7:0]  gotLog[$];

  always #10 clk = ~clk;

  nibble_reg_port u0 (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid),
    .inReady(inReady), .rspData(rspData), .rspValid(rspValid),
    .rspReady(rspReady), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  assign regRdData = rf[regAddr];
  always @(posedge clk) if (regWrEn) rf[regAddr] <= regWrData;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: scoreboard for responses and writes
  always @(negedge clk) begin
    #2;
    if (rstN) begin
      if (rspValid && rspReady) begin
        if (expRsp.size() == 0) chk("R8 unexpected response", {24'h0, rspData}, 32'hFFFF_FFFF);
        else begin
          string t;
          logic [7:0] e;
          e = expRsp.pop_front();
          t = rspTag.pop_front();
          gotLog.push_back(rspData);
          chk(t, {24'h0, rspData}, {24'h0, e});
        end
      end
      if (regWrEn) begin
        if (expWr.size() == 0) chk("R8 unexpected write", {16'h0, regAddr, regWrData}, 32'hFFFF_FFFF);
        else chk("R3 R4 write addr/data", {16'h0, regAddr, regWrData}, {16'h0, expWr.pop_front()});
      end
    end
  end

  task automatic sendByte(logic [7:0] b);
    inData  = b;
    inValid = 1'b1;
    #1;
    while (!inReady) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic setAddr(logic [7:0] a);
    sendByte({4'h0, a[3:0]});
    sendByte({4'h1, a[7:4]});
    mAddr = a;
  endtask

  task automatic writeByte(logic [7:0] d);
    expWr.push_back({mAddr, d});
    expMem[mAddr] = d;
    sendByte({4'h2, d[3:0]});
    sendByte({4'h3, d[7:4]});
    mAddr = mAddr + 8'd1;
  endtask

  task automatic readByte(logic nxt, string tag);
    expRsp.push_back(expMem[mAddr]);
    rspTag.push_back(tag);
    sendByte({4'h4, 3'b000, nxt});
    if (nxt) mAddr = mAddr + 8'd1;
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    chk("watchdog expired", 32'h0, 32'h1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      rf[i]     = 8'(i) ^ 8'hA5;
      expMem[i] = 8'(i) ^ 8'hA5;
    end
    mAddr = 8'h00;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    chk("R1 rspValid after reset", {31'h0, rspValid}, 32'h0);
    chk("R1 regWrEn after reset", {31'h0, regWrEn}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 inReady after reset", {31'h0, inReady}, 32'h1);
    chk("R1 address after reset", {24'h0, regAddr}, 32'h0);
    readByte(1'b0, "R1 read of register 0 after reset");
    drain();

    // R2: nibble-wise address
    setAddr(8'h3C);
    #1;
    chk("R2 address from two nibbles", {24'h0, regAddr}, 32'h3C);
    sendByte(8'h07);
    mAddr = 8'h37;
    #1;
    chk("R2 low nibble only", {24'h0, regAddr}, 32'h37);
    readByte(1'b0, "R5 single read");
    drain();

    // R3 R4: burst write, then read back
    setAddr(8'h40);
    writeByte(8'h12);
    writeByte(8'hF0);
    writeByte(8'h9B);
    #1;
    chk("R4 address after three writes", {24'h0, regAddr}, 32'h43);
    // R3: data-low alone writes nothing; a repeated high half reuses the low nibble
    sendByte(8'h2E);
    #1;
    chk("R3 no write on data-low", {31'h0, regWrEn}, 32'h0);
    expWr.push_back({mAddr, 8'h7E}); expMem[mAddr] = 8'h7E; sendByte(8'h37); mAddr++;
    expWr.push_back({mAddr, 8'h1E}); expMem[mAddr] = 8'h1E; sendByte(8'h31); mAddr++;
    setAddr(8'h40);
    for (int k = 0; k < 5; k++) readByte(1'b1, "R3 R6 burst readback");
    drain();

    // R6: read without flag keeps the address
    setAddr(8'h41);
    readByte(1'b0, "R6 no-advance read 1");
    readByte(1'b0, "R6 no-advance read 2");
    drain();
    #1;
    chk("R6 address unchanged", {24'h0, regAddr}, 32'h41);

    // R7: wrap at the top of the address range
    setAddr(8'hFF);
    writeByte(8'hC3);
    writeByte(8'h3C);
    #1;
    chk("R7 address wraps after write", {24'h0, regAddr}, 32'h01);
    setAddr(8'hFF);
    readByte(1'b1, "R7 read at 0xFF");
    readByte(1'b1, "R7 read after wrap");
    drain();

    // R8: unknown codes are dropped
    setAddr(8'h30);
    sendByte(8'h5A);
    sendByte(8'h97);
    sendByte(8'hFF);
    sendByte(8'hE1);
    #1;
    chk("R8 address after unknown codes", {24'h0, regAddr}, 32'h30);
    readByte(1'b0, "R8 register intact after unknown codes");
    drain();

    // R10: two 24-bit little-endian positions in six registers
    setAddr(8'h20);
    writeByte(8'h56); writeByte(8'h34); writeByte(8'h12);
    writeByte(8'hEF); writeByte(8'hCD); writeByte(8'hAB);
    setAddr(8'h20);
    gotLog.delete();
    for (int k = 0; k < 6; k++) readByte(1'b1, "R10 position burst");
    drain();
    if (gotLog.size() == 6) begin
      chk("R10 first position", {8'h0, gotLog[2], gotLog[1], gotLog[0]}, 32'h123456);
      chk("R10 second position", {8'h0, gotLog[5], gotLog[4], gotLog[3]}, 32'hABCDEF);
    end else chk("R10 byte count", gotLog.size(), 6);

    // R9: backpressure
    setAddr(8'h50);
    rspReady = 1'b0;
    expRsp.push_back(expMem[8'h50]);
    rspTag.push_back("R9 response after stall");
    sendByte(8'h40);
    inData  = 8'h05;
    inValid = 1'b1;
    #1;
    chk("R9 inReady low while stalled", {31'h0, inReady}, 32'h0);
    chk("R9 rspValid high while stalled", {31'h0, rspValid}, 32'h1);
    chk("R9 rspData during stall", {24'h0, rspData}, {24'h0, expMem[8'h50]});
    repeat (3) @(negedge clk);
    #1;
    chk("R9 rspData held", {24'h0, rspData}, {24'h0, expMem[8'h50]});
    chk("R9 address held while stalled", {24'h0, regAddr}, 32'h50);
    @(negedge clk);
    rspReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    mAddr = 8'h55;
    #1;
    chk("R9 queued byte taken after release", {24'h0, regAddr}, 32'h55);
    drain();

    chk("scoreboard responses drained", expRsp.size(), 0);
    chk("scoreboard writes drained", expWr.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule